// File: doc/BRIEF.md
# Serial Port Register Block

This block is the processor-facing side of a serial port. A simple word-wide register bus reaches four 32-bit registers: a control word, a receive data port, a transmit data port and a status word. Behind the registers sit two byte FIFOs. Software writes bytes into the transmit FIFO and reads bytes out of the receive FIFO. A separate serial frame engine drains the transmit FIFO and fills the receive FIFO through byte-wide valid/ready handshakes.

The status word reports FIFO full and empty conditions, a selectable occupancy level, a transmitter-busy bit from the frame engine, two interrupt-pending flags and three sticky error flags. Software clears the pending and error flags by writing 1 to them. A single active-high interrupt line combines the two pending flags, each gated by its own enable. The two DMA enable bits are held in the control word and read back, and nothing else uses them.

Register offsets: control 0x0, receive data 0x4, transmit data 0x8, status 0xC. A bus access is one cycle with `bus_req` high. Read data is valid during that cycle, and a receive-data read pops at the closing clock edge.

Top module: `uart_regif`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000_0420 (receive-empty bit 5 and transmit-empty bit 10 set), and `irq` and `tx_valid` are low.
- R2: Control bits 14 (level select), 15 (global enable), 16 (receive DMA enable), 17 (transmit DMA enable), 18 (receive interrupt enable) and 19 (transmit interrupt enable) read back as written. All other control bits read 0.
- R3: A write to offset 0x8 pushes `bus_wdata[7:0]` into the transmit FIFO. While the global enable is set, `tx_valid`/`tx_data` present the bytes to the frame engine in write order. Status bit 6 is set while the FIFO is full and bit 10 while it is empty.
- R4: A write to offset 0x8 while the transmit FIFO is full is dropped and sets sticky status bit 3.
- R5: A byte accepted from the frame engine is stored. A read of offset 0x4 returns the oldest byte in bits 7:0 with bits 31:8 zero, and pops it.
- R6: A read of offset 0x4 while the receive FIFO is empty returns 0 and leaves the FIFO empty, with status bit 5 still set and a level of 0.
- R7: A byte from the frame engine that arrives while the receive FIFO is full is dropped and sets sticky status bit 2. A byte that arrives with `rx_err` high sets sticky status bit 4.
- R8: Status bits 16:11 report the transmit FIFO occupancy when control bit 14 is 1 and the receive FIFO occupancy when it is 0.
- R9: Status bit 0 (receive pending) sets on each accepted receive byte. Status bit 1 (transmit pending) sets each time the frame engine takes a byte. Writing 1 to any of status bits 0 to 4 clears that bit, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly while (status bit 0 and control bit 18) or (status bit 1 and control bit 19).
- R11: While the global enable is 0, `rx_ready` and `tx_valid` are low, incoming bytes are ignored and the pending flags do not set.
- R12: Status bit 17 follows the frame engine's `tx_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_req` is high |
| irq | output | 1 | Level-high interrupt |
| tx_valid | output | 1 | Transmit byte available for the frame engine |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Frame engine takes the byte |
| tx_busy | input | 1 | Frame engine is shifting out a frame |
| rx_valid | input | 1 | Frame engine offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Offered byte had a parity or framing error |
| rx_ready | output | 1 | Block accepts received bytes |

## Verification
The bench builds the block with a 16-entry transmit FIFO and a 4-entry receive FIFO. The deep transmit side checks a full sixteen-byte fill, the dropped seventeenth write and a level of 16 in the 6-bit field. The shallow receive side reaches overrun after five offered bytes, so the bench can confirm that the fifth byte is lost while the first four come back in order.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int REG_AW = 4;
  localparam int LVL_W  = 6;

  localparam logic [REG_AW-1:0] OFF_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFF_RXD  = 4'h4;
  localparam logic [REG_AW-1:0] OFF_TXD  = 4'h8;
  localparam logic [REG_AW-1:0] OFF_STAT = 4'hC;

  // control word bit positions
  localparam int CB_LVLSEL = 14;
  localparam int CB_EN     = 15;
  localparam int CB_RXDMA  = 16;
  localparam int CB_TXDMA  = 17;
  localparam int CB_RXIE   = 18;
  localparam int CB_TXIE   = 19;

  // status word bit positions; flag indices 0..4 equal their status bits
  localparam int NFLAG      = 5;
  localparam int SB_RXPEND  = 0;
  localparam int SB_TXPEND  = 1;
  localparam int SB_OVR     = 2;
  localparam int SB_TXERR   = 3;
  localparam int SB_RXERR   = 4;
  localparam int SB_RXEMPTY = 5;
  localparam int SB_TXFULL  = 6;
  localparam int SB_TXEMPTY = 10;
  localparam int SB_LVL_LO  = 11;
  localparam int SB_BUSY    = 17;

  typedef struct packed {
    logic tx_ie;
    logic rx_ie;
    logic tx_dma;
    logic rx_dma;
    logic en;
    logic lvl_sel;
  } ctrl_t;

endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, upd;

  assign full    = (cnt_q == CMAX);
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem[rptr_q];

  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign upd     = do_push | do_pop;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage carries no reset; only written entries are ever read out
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

endmodule

// File: rtl/uart_regif_flags.sv
module uart_regif_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] d;
  logic         upd;

  // a set event in the same cycle as a clear keeps the flag
  for (genvar i = 0; i < N; i++) begin : g_flag
    assign d[i] = set_i[i] | (q_o[i] & ~clr_i[i]);
  end

  assign upd = (|set_i) | (|clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= '0;
    else if (upd) q_o <= d;
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        tx_busy,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_err,
  output logic        rx_ready
);

  // the level field is six bits wide, so each depth must stay below 64
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // bus decode
  logic wr_ctrl, wr_txd, wr_stat, rd_rxd;

  assign wr_ctrl = bus_req &  bus_we & (bus_addr == OFF_CTRL);
  assign wr_txd  = bus_req &  bus_we & (bus_addr == OFF_TXD);
  assign wr_stat = bus_req &  bus_we & (bus_addr == OFF_STAT);
  assign rd_rxd  = bus_req & ~bus_we & (bus_addr == OFF_RXD);

  // control word
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d.lvl_sel = bus_wdata[CB_LVLSEL];
    ctrl_d.en      = bus_wdata[CB_EN];
    ctrl_d.rx_dma  = bus_wdata[CB_RXDMA];
    ctrl_d.tx_dma  = bus_wdata[CB_TXDMA];
    ctrl_d.rx_ie   = bus_wdata[CB_RXIE];
    ctrl_d.tx_ie   = bus_wdata[CB_TXIE];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // transmit path
  logic           tx_full, tx_empty, tx_pop;
  logic [TCW-1:0] tx_cnt;

  assign tx_valid = ctrl_q.en & ~tx_empty;
  assign tx_pop   = tx_valid & tx_ready;

  uart_regif_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (wr_txd),
    .din   (bus_wdata[7:0]),
    .pop   (tx_pop),
    .dout  (tx_data),
    .full  (tx_full),
    .empty (tx_empty),
    .count (tx_cnt)
  );

  // receive path: every offered byte is taken while enabled, dropped when full
  logic           rx_full, rx_empty, rx_take, rx_ok, rx_drop;
  logic [7:0]     rx_head;
  logic [RCW-1:0] rx_cnt;

  assign rx_ready = ctrl_q.en;
  assign rx_take  = rx_valid & ctrl_q.en;
  assign rx_ok    = rx_take & ~rx_full;
  assign rx_drop  = rx_take &  rx_full;

  uart_regif_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (rx_take),
    .din   (rx_data),
    .pop   (rd_rxd),
    .dout  (rx_head),
    .full  (rx_full),
    .empty (rx_empty),
    .count (rx_cnt)
  );

  // pending and error flags
  logic [NFLAG-1:0] flag_set, flag_clr, flags_q;

  always_comb begin
    flag_set            = '0;
    flag_set[SB_RXPEND] = rx_ok;
    flag_set[SB_TXPEND] = tx_pop;
    flag_set[SB_OVR]    = rx_drop;
    flag_set[SB_TXERR]  = wr_txd & tx_full;
    flag_set[SB_RXERR]  = rx_take & rx_err;
    flag_clr            = wr_stat ? bus_wdata[NFLAG-1:0] : '0;
  end

  uart_regif_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flags_q)
  );

  assign irq = (flags_q[SB_RXPEND] & ctrl_q.rx_ie) |
               (flags_q[SB_TXPEND] & ctrl_q.tx_ie);

  // read data
  logic [LVL_W-1:0] lvl;
  logic [31:0]      ctrl_word, stat_word;

  assign lvl = ctrl_q.lvl_sel ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CB_LVLSEL] = ctrl_q.lvl_sel;
    ctrl_word[CB_EN]     = ctrl_q.en;
    ctrl_word[CB_RXDMA]  = ctrl_q.rx_dma;
    ctrl_word[CB_TXDMA]  = ctrl_q.tx_dma;
    ctrl_word[CB_RXIE]   = ctrl_q.rx_ie;
    ctrl_word[CB_TXIE]   = ctrl_q.tx_ie;

    stat_word                            = '0;
    stat_word[NFLAG-1:0]                 = flags_q;
    stat_word[SB_RXEMPTY]                = rx_empty;
    stat_word[SB_TXFULL]                 = tx_full;
    stat_word[SB_TXEMPTY]                = tx_empty;
    stat_word[SB_LVL_LO+LVL_W-1:SB_LVL_LO] = lvl;
    stat_word[SB_BUSY]                   = tx_busy;
  end

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL: bus_rdata = ctrl_word;
      OFF_RXD:  bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
      OFF_STAT: bus_rdata = stat_word;
      default:  bus_rdata = 32'h0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:20], bus_wdata[13:8]};

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        rx_pend,
  input logic        tx_pend,
  input logic        ovr,
  input logic        tx_err,
  input logic        en,
  input logic        tx_valid,
  input logic        rx_valid,
  input logic        wr_stat,
  input logic        wr_txd,
  input logic        rd_rxd,
  input logic        clr_ovr,
  input logic        tx_full,
  input logic        tx_empty,
  input logic        rx_empty,
  input logic [31:0] rdata
);

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_pend || tx_pend));

  assert_tx_valid_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> en);

  assert_rx_pend_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_pend) |-> $past(rx_valid && en));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_stat && clr_ovr)) |=> ovr);

  assert_tx_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_empty) |-> (rdata == 32'h0));

  assert_tx_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_full) |=> tx_err);

endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq),
  .rx_pend  (flags_q[0]),
  .tx_pend  (flags_q[1]),
  .ovr      (flags_q[2]),
  .tx_err   (flags_q[3]),
  .en       (ctrl_q.en),
  .tx_valid (tx_valid),
  .rx_valid (rx_valid),
  .wr_stat  (wr_stat),
  .wr_txd   (wr_txd),
  .rd_rxd   (rd_rxd),
  .clr_ovr  (bus_wdata[2]),
  .tx_full  (tx_full),
  .tx_empty (tx_empty),
  .rx_empty (rx_empty),
  .rdata    (bus_rdata)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TXD = 16;
  localparam int RXD = 4;

  localparam logic [31:0] C_LVL  = 32'h0000_4000;
  localparam logic [31:0] C_EN   = 32'h0000_8000;
  localparam logic [31:0] C_RXIE = 32'h0004_0000;
  localparam logic [31:0] C_TXIE = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, tx_valid, tx_ready, tx_busy, rx_valid, rx_err, rx_ready;
  logic [7:0]  tx_data, rx_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err(rx_err), .rx_ready(rx_ready)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [7:0] b);
    @(negedge clk);
    v = tx_valid; b = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic logic [31:0] lvl_of(input logic [31:0] s);
    return (s >> 11) & 32'h3f;
  endfunction

  task automatic t_reset;
    logic [31:0] s;
    rd(4'h0, s); chk("R1 ctrl", s, 32'h0);
    rd(4'hC, s); chk("R1 status", s, 32'h0000_0420);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] s;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, s); chk("R2 all ones", s, 32'h000F_C000);
    wr(4'h0, 32'h0002_8000);
    rd(4'h0, s); chk("R2 pattern", s, 32'h0002_8000);
    wr(4'h0, 32'h0);
    rd(4'h0, s); chk("R2 cleared", s, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] s;
    logic v;
    logic [7:0] b;
    chk("R11 rx_ready low", {31'h0, rx_ready}, 32'h0);
    rx_send(8'h55, 1'b0);
    rd(4'hC, s); chk("R11 rx ignored", s & 32'h21, 32'h20);
    wr(4'h8, 32'hA1);
    #1 chk("R11 tx_valid low", {31'h0, tx_valid}, 32'h0);
    wr(4'h0, C_EN);
    #1 chk("R3 tx_valid on enable", {31'h0, tx_valid}, 32'h1);
    tx_take(v, b);
    chk("R3 first byte", {24'h0, b}, 32'hA1);
    rd(4'hC, s); chk("R9 tx pend set by pop", s & 32'h2, 32'h2);
    wr(4'hC, 32'h0);
    rd(4'hC, s); chk("R9 write 0 keeps", s & 32'h2, 32'h2);
    wr(4'hC, 32'h2);
    rd(4'hC, s); chk("R9 w1c tx pend", s & 32'h2, 32'h0);
  endtask

  task automatic t_tx_order;
    logic [31:0] s;
    logic v;
    logic [7:0] b;
    wr(4'h8, 32'h11); wr(4'h8, 32'hFFFF_FF22); wr(4'h8, 32'h33);
    rd(4'hC, s); chk("R3 not empty", s & 32'h400, 32'h0);
    tx_take(v, b); chk("R3 order 0", {23'h0, v, b}, 32'h111);
    tx_take(v, b); chk("R3 order 1", {23'h0, v, b}, 32'h122);
    tx_take(v, b); chk("R3 order 2", {23'h0, v, b}, 32'h133);
    rd(4'hC, s); chk("R3 empty again", s & 32'h440, 32'h400);
    wr(4'hC, 32'h2);
  endtask

  task automatic t_tx_full;
    logic [31:0] s;
    logic v;
    logic [7:0] b;
    wr(4'h0, C_EN | C_LVL);
    for (int i = 0; i < TXD; i++) wr(4'h8, 32'h40 + i);
    rd(4'hC, s);
    chk("R3 full bit", s & 32'h440, 32'h40);
    chk("R8 tx level", lvl_of(s), TXD);
    wr(4'h8, 32'hEE);
    rd(4'hC, s);
    chk("R4 tx error", s & 32'h8, 32'h8);
    chk("R4 level kept", lvl_of(s), TXD);
    for (int i = 0; i < TXD; i++) begin
      tx_take(v, b);
      chk("R4 drained byte", {23'h0, v, b}, 32'h100 + 32'h40 + i);
    end
    #1 chk("R4 extra byte dropped", {31'h0, tx_valid}, 32'h0);
    wr(4'hC, 32'h0);
    rd(4'hC, s); chk("R9 write 0 keeps error", s & 32'h8, 32'h8);
    wr(4'hC, 32'hA);
    rd(4'hC, s); chk("R9 w1c tx error", s & 32'h1F, 32'h0);
  endtask

  task automatic t_rx;
    logic [31:0] s;
    wr(4'h0, C_EN | C_RXIE);
    rx_send(8'h5A, 1'b0);
    rx_send(8'hC3, 1'b0);
    rd(4'hC, s);
    chk("R9 rx pend", s & 32'h21, 32'h1);
    chk("R8 rx level", lvl_of(s), 32'd2);
    chk("R10 irq rx", {31'h0, irq}, 32'h1);
    rd(4'h4, s); chk("R5 first byte", s, 32'h5A);
    rd(4'h4, s); chk("R5 second byte", s, 32'hC3);
    wr(4'hC, 32'h1);
    #1 chk("R10 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rx_empty;
    logic [31:0] s;
    rd(4'h4, s); chk("R6 empty read", s, 32'h0);
    rd(4'hC, s);
    chk("R6 still empty", s & 32'h20, 32'h20);
    chk("R6 level zero", lvl_of(s), 32'h0);
  endtask

  task automatic t_overrun;
    logic [31:0] s;
    for (int i = 0; i < RXD + 1; i++) rx_send(8'h80 + 8'(i), 1'b0);
    rd(4'hC, s);
    chk("R7 overrun", s & 32'h14, 32'h4);
    chk("R7 level full", lvl_of(s), RXD);
    for (int i = 0; i < RXD; i++) begin
      rd(4'h4, s); chk("R7 kept byte", s, 32'h80 + i);
    end
    rd(4'hC, s); chk("R7 fifth dropped", s & 32'h20, 32'h20);
    rx_send(8'h3C, 1'b1);
    rd(4'hC, s); chk("R7 rx error", s & 32'h10, 32'h10);
    rd(4'h4, s); chk("R7 errored byte stored", s, 32'h3C);
    wr(4'hC, 32'h15);
    rd(4'hC, s); chk("R9 w1c rx flags", s & 32'h1F, 32'h0);
  endtask

  task automatic t_irq_tx;
    logic [31:0] s;
    logic v;
    logic [7:0] b;
    wr(4'h0, C_EN | C_TXIE);
    wr(4'h8, 32'h77);
    tx_take(v, b);
    #1 chk("R10 irq tx", {31'h0, irq}, 32'h1);
    wr(4'h0, C_EN);
    #1 chk("R10 irq masked", {31'h0, irq}, 32'h0);
    rd(4'hC, s); chk("R10 pend kept", s & 32'h2, 32'h2);
    wr(4'hC, 32'h2);
  endtask

  task automatic t_busy;
    logic [31:0] s;
    @(negedge clk) tx_busy = 1'b1;
    rd(4'hC, s); chk("R12 busy high", s & 32'h2_0000, 32'h2_0000);
    @(negedge clk) tx_busy = 1'b0;
    rd(4'hC, s); chk("R12 busy low", s & 32'h2_0000, 32'h0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired for all R1 to R12 checks");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 1'b0; tx_busy = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_disabled();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_rx_empty();
    t_overrun();
    t_irq_tx();
    t_busy();
    finish_run();
  end

endmodule